// File: doc/BRIEF.md
# Early-exit vector length truncation unit

This block follows the per-element results of a vector operation as they come in and decides whether, and where, the operation stops early. A start pulse loads the operation's settings: the current vector length, the group size, the zeroing-predication flag and the stopping mode. After that, one element is presented per cycle in index order. Each element carries a predicate bit, a trap-request flag and a pass/fail condition result.

There are two stopping modes. In trap mode, a trap in the first group is handed on unchanged, so that it behaves like a scalar trap. A trap in any later group ends processing instead. In condition mode, the first failing element ends processing. In both modes, truncation removes whole groups. The new vector length counts the complete groups before the stopping point, and this count includes masked-out groups. When processing stops, the unit also reports the group index and the position inside the group of the element that caused the stop, so that a handler can locate it. The group size itself is never changed.

Top module: `elem_stop_vl`

## Requirements
- R1: If `trap_en` and `cond_en` are both high at start, `mode_err` is high from the next cycle until the next start. While it is high, no element causes `stop_pulse` or `trap_pass`, and `vl_out` keeps the loaded length.
- R2: A start pulse loads the settings and rearms the unit. In the next cycle `vl_out` equals `vl_in`, and both strobes are low. Element inputs presented in the start cycle are ignored.
- R3: In trap mode, an active element of group 0 that requests a trap raises `trap_pass` for one cycle, one cycle after the element. `vl_out` is unchanged and no stop occurs.
- R4: In trap mode, an active element in group g > 0 that requests a trap raises `stop_pulse` one cycle later and sets `vl_out` to g. All later elements are ignored until the next start.
- R5: A masked-out element (group predicate 0) never causes a trap-mode stop or a `trap_pass`. Its group still counts in `vl_out`.
- R6: Trap-mode results do not depend on `zero_mode`.
- R7: In condition mode, an active element with `elem_pass`=0 in group g stops processing: `stop_pulse` is high one cycle later and `vl_out`=g. This applies to g=0 as well.
- R8: In condition mode with `zero_mode`=0, the elements of a masked-out group are treated as passing.
- R9: In condition mode with `zero_mode`=1, any element of a masked-out group stops processing.
- R10: The group size is `subvl_m1`+1. A stop removes the whole group it falls in. `stop_group` and `stop_sub` report the stopping element's group index and its offset within the group, and `stop_sub` never exceeds `subvl_m1`.
- R11: If nothing stops processing, `vl_out` stays equal to the loaded length and `stop_pulse` stays low. Elements beyond the loaded length (group index >= length) are ignored.
- R12: The predicate of a group is the `elem_pred` value presented with its first element (offset 0). `elem_pred` is ignored for the other elements of the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Load settings and rearm |
| vl_in | input | VL_W | Current vector length in groups |
| subvl_m1 | input | SUB_W | Group size minus one |
| zero_mode | input | 1 | Zeroing predication |
| trap_en | input | 1 | Request trap stopping mode |
| cond_en | input | 1 | Request condition stopping mode |
| elem_valid | input | 1 | Element present this cycle |
| elem_pred | input | 1 | Predicate bit (sampled at group offset 0) |
| elem_trap | input | 1 | Element requests a trap |
| elem_pass | input | 1 | Element condition result (1 = pass) |
| vl_out | output | VL_W | Truncated vector length |
| stop_pulse | output | 1 | One-cycle stop strobe |
| trap_pass | output | 1 | One-cycle strobe: first-group trap is passed on |
| stop_group | output | VL_W | Group index of the stopping element |
| stop_sub | output | SUB_W | Offset within its group of the stopping element |
| mode_err | output | 1 | Both modes were requested at start |

## Verification
The sweep covers group sizes 1 to 3 and lengths 1 to 4, in both modes and both zeroing settings. It places one bad element at every element position, and also runs with no bad element, under four group predicate patterns: all on, all off, and two alternating patterns.

The alternating patterns separate the two masked-out treatments: passing without zeroing and failing with zeroing. They also show whether masked groups are counted in the new length. A bad element placed at a non-zero offset inside a group shows whether the whole group is removed and whether the offset is reported. A bad element in group 0 separates the trap hand-off from a stop.

The sweep also drives `elem_pred` inverted on non-first elements, which shows whether the predicate is held for the whole group. It sends one extra group of bad elements past the length, which must be ignored. A final run with both modes requested checks the error flag.

// File: rtl/elem_stop_pkg.sv
// Package: shared types for the early-exit vector length unit.
// Assumes nothing beyond IEEE 1800-2017.
package elem_stop_pkg;

    // Stopping mode decoded from the two request bits at start.
    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,
        MODE_TRAP = 2'd1,
        MODE_COND = 2'd2,
        MODE_BAD  = 2'd3
    } stop_mode_e;

    // Decode the two request bits into a mode.
    function automatic stop_mode_e decode_mode(input logic trap_req, input logic cond_req);
        stop_mode_e m;
        case ({cond_req, trap_req})
            2'b01:   m = MODE_TRAP;
            2'b10:   m = MODE_COND;
            2'b11:   m = MODE_BAD;
            default: m = MODE_NONE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/esv_cfg_latch.sv
// Module: esv_cfg_latch
// Holds the operation settings captured on a start pulse.
// Assumes start is a single-cycle pulse; settings are stable only while
// they are sampled at start.
module esv_cfg_latch
    import elem_stop_pkg::*;
#(
    parameter int VL_W  = 6,
    parameter int SUB_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VL_W-1:0]  vl_in,
    input  logic [SUB_W-1:0] subvl_m1,
    input  logic             zero_mode,
    input  logic             trap_en,
    input  logic             cond_en,
    output logic [VL_W-1:0]  cfg_vl,
    output logic [SUB_W-1:0] cfg_sub_last,
    output logic             cfg_zero,
    output stop_mode_e       cfg_mode
);

    // Capture all settings on start, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_vl       <= '0;
            cfg_sub_last <= '0;
            cfg_zero     <= 1'b0;
            cfg_mode     <= MODE_NONE;
        end else if (start) begin
            cfg_vl       <= vl_in;
            cfg_sub_last <= subvl_m1;
            cfg_zero     <= zero_mode;
            cfg_mode     <= decode_mode(trap_en, cond_en);
        end
    end

endmodule

// File: rtl/esv_position.sv
// Module: esv_position
// Tracks the group index and the offset within the group of the next
// element, and holds the predicate sampled at offset 0 of each group.
// Assumes accept is only raised for in-range elements, so the group counter
// never passes cfg_vl.
module esv_position #(
    parameter int VL_W  = 6,
    parameter int SUB_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             accept,
    input  logic [SUB_W-1:0] sub_last,
    input  logic [VL_W-1:0]  cfg_vl,
    input  logic             pred_in,
    output logic [VL_W-1:0]  grp,
    output logic [SUB_W-1:0] sub,
    output logic             in_range,
    output logic             pred_eff
);

    logic pred_hold;
    logic last_of_grp;

    // Element position and group-end detection.
    always_comb begin
        last_of_grp = (sub == sub_last);
        in_range    = (grp < cfg_vl);
        pred_eff    = (sub == '0) ? pred_in : pred_hold;
    end

    // Advance the position on each accepted element; restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            grp <= '0;
            sub <= '0;
        end else if (accept) begin
            if (last_of_grp) begin
                sub <= '0;
                grp <= grp + 1'b1;
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end

    // Hold the group predicate taken from its first element.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pred_hold <= 1'b0;
        end else if (accept && (sub == '0)) begin
            pred_hold <= pred_in;
        end
    end

endmodule

// File: rtl/esv_judge.sv
// Module: esv_judge
// Combinational decision for one element: whether it ends processing or
// whether its trap is handed on untouched.
// Assumes pred is the group predicate already resolved by esv_position.
module esv_judge
    import elem_stop_pkg::*;
(
    input  stop_mode_e mode,
    input  logic       zero,
    input  logic       pred,
    input  logic       trap,
    input  logic       pass,
    input  logic       first_grp,
    output logic       stop_req,
    output logic       trap_fwd
);

    logic trap_hit;
    logic cond_fail;

    // Evaluate the element against the active mode.
    always_comb begin
        trap_hit  = pred & trap;
        cond_fail = pred ? ~pass : zero;
        stop_req  = 1'b0;
        trap_fwd  = 1'b0;
        case (mode)
            MODE_TRAP: begin
                stop_req = trap_hit & ~first_grp;
                trap_fwd = trap_hit & first_grp;
            end
            MODE_COND: begin
                stop_req = cond_fail;
            end
            default: begin
                stop_req = 1'b0;
                trap_fwd = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/elem_stop_vl.sv
// Module: elem_stop_vl (top)
// Watches elements in index order, one per cycle, and truncates the vector
// length to whole groups before the first stopping element.
// Assumes elements arrive in order after a start pulse, and that a new
// start is issued for each operation.
module elem_stop_vl
    import elem_stop_pkg::*;
#(
    parameter int VL_W  = 6,
    parameter int SUB_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VL_W-1:0]  vl_in,
    input  logic [SUB_W-1:0] subvl_m1,
    input  logic             zero_mode,
    input  logic             trap_en,
    input  logic             cond_en,
    input  logic             elem_valid,
    input  logic             elem_pred,
    input  logic             elem_trap,
    input  logic             elem_pass,
    output logic [VL_W-1:0]  vl_out,
    output logic             stop_pulse,
    output logic             trap_pass,
    output logic [VL_W-1:0]  stop_group,
    output logic [SUB_W-1:0] stop_sub,
    output logic             mode_err
);

    logic [VL_W-1:0]  cfg_vl;
    logic [SUB_W-1:0] cfg_sub_last;
    logic             cfg_zero;
    stop_mode_e       cfg_mode;
    logic [VL_W-1:0]  grp;
    logic [SUB_W-1:0] sub;
    logic             in_range;
    logic             pred_eff;
    logic             armed;
    logic             accept;
    logic             stop_req;
    logic             trap_fwd;

    esv_cfg_latch #(.VL_W(VL_W), .SUB_W(SUB_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .vl_in        (vl_in),
        .subvl_m1     (subvl_m1),
        .zero_mode    (zero_mode),
        .trap_en      (trap_en),
        .cond_en      (cond_en),
        .cfg_vl       (cfg_vl),
        .cfg_sub_last (cfg_sub_last),
        .cfg_zero     (cfg_zero),
        .cfg_mode     (cfg_mode)
    );

    esv_position #(.VL_W(VL_W), .SUB_W(SUB_W)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .accept   (accept),
        .sub_last (cfg_sub_last),
        .cfg_vl   (cfg_vl),
        .pred_in  (elem_pred),
        .grp      (grp),
        .sub      (sub),
        .in_range (in_range),
        .pred_eff (pred_eff)
    );

    esv_judge u_judge (
        .mode      (cfg_mode),
        .zero      (cfg_zero),
        .pred      (pred_eff),
        .trap      (elem_trap),
        .pass      (elem_pass),
        .first_grp (grp == '0),
        .stop_req  (stop_req),
        .trap_fwd  (trap_fwd)
    );

    // An element counts only while armed, in range and not during start.
    always_comb begin
        accept = elem_valid & armed & in_range & ~start;
    end

    // Arm on start, disarm on the first stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (start) begin
            armed <= 1'b1;
        end else if (accept && stop_req) begin
            armed <= 1'b0;
        end
    end

    // Register the truncated length and the stopping position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_out     <= '0;
            stop_group <= '0;
            stop_sub   <= '0;
        end else if (start) begin
            vl_out     <= vl_in;
            stop_group <= '0;
            stop_sub   <= '0;
        end else if (accept && stop_req) begin
            vl_out     <= grp;
            stop_group <= grp;
            stop_sub   <= sub;
        end
    end

    // One-cycle strobes for a stop or a first-group trap hand-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_pulse <= 1'b0;
            trap_pass  <= 1'b0;
        end else begin
            stop_pulse <= accept & stop_req;
            trap_pass  <= accept & trap_fwd;
        end
    end

    // Error flag for a start that requested both modes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_err <= 1'b0;
        end else if (start) begin
            mode_err <= trap_en & cond_en;
        end
    end

endmodule

// File: rtl/elem_stop_vl_chk.sv
// Module: elem_stop_vl_chk
// Port-level temporal checks for elem_stop_vl, attached by bind.
// Assumes a synchronous active-low reset.
module elem_stop_vl_chk #(
    parameter int VL_W  = 6,
    parameter int SUB_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [VL_W-1:0]  vl_in,
    input logic [SUB_W-1:0] subvl_m1,
    input logic [VL_W-1:0]  vl_out,
    input logic             stop_pulse,
    input logic             trap_pass,
    input logic [VL_W-1:0]  stop_group,
    input logic [SUB_W-1:0] stop_sub,
    input logic             mode_err
);

    logic [VL_W-1:0]  own_vl;
    logic [SUB_W-1:0] own_sub;

    // Checker copy of the loaded length and group size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_vl  <= '0;
            own_sub <= '0;
        end else if (start) begin
            own_vl  <= vl_in;
            own_sub <= subvl_m1;
        end
    end

    p_err_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (!stop_pulse && !trap_pass && vl_out == own_vl));

    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!stop_pulse && !trap_pass && vl_out == $past(vl_in)));

    p_pass_no_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pass |-> !stop_pulse);

    p_stop_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> (vl_out == stop_group));

    p_single_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse);

    p_sub_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> (stop_sub <= own_sub));

    p_len_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vl_out <= own_vl);

endmodule

bind elem_stop_vl elem_stop_vl_chk #(.VL_W(VL_W), .SUB_W(SUB_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .vl_in      (vl_in),
    .subvl_m1   (subvl_m1),
    .vl_out     (vl_out),
    .stop_pulse (stop_pulse),
    .trap_pass  (trap_pass),
    .stop_group (stop_group),
    .stop_sub   (stop_sub),
    .mode_err   (mode_err)
);

// File: tb/elem_stop_vl_bench.sv
module elem_stop_vl_bench;
    localparam int VL_W  = 6;
    localparam int SUB_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [VL_W-1:0]  vl_in = '0;
    logic [SUB_W-1:0] subvl_m1 = '0;
    logic             zero_mode = 1'b0;
    logic             trap_en = 1'b0;
    logic             cond_en = 1'b0;
    logic             elem_valid = 1'b0;
    logic             elem_pred = 1'b0;
    logic             elem_trap = 1'b0;
    logic             elem_pass = 1'b1;
    logic [VL_W-1:0]  vl_out;
    logic             stop_pulse;
    logic             trap_pass;
    logic [VL_W-1:0]  stop_group;
    logic [SUB_W-1:0] stop_sub;
    logic             mode_err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    elem_stop_vl #(.VL_W(VL_W), .SUB_W(SUB_W)) u_elem_stop_vl (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
        .subvl_m1(subvl_m1), .zero_mode(zero_mode), .trap_en(trap_en),
        .cond_en(cond_en), .elem_valid(elem_valid), .elem_pred(elem_pred),
        .elem_trap(elem_trap), .elem_pass(elem_pass), .vl_out(vl_out),
        .stop_pulse(stop_pulse), .trap_pass(trap_pass),
        .stop_group(stop_group), .stop_sub(stop_sub), .mode_err(mode_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One operation: mode 1 = trap, 2 = condition, 3 = both requested.
    // Group predicate g is bit g of pmask; bad element index is bad_e.
    task automatic run_op(input int mode, input int zm, input int sub,
                          input int vl, input int bad_e, input int pmask);
        int exp_vl = vl, exp_stops = 0, exp_traps = 0, exp_g = 0, exp_s = 0;
        int got_stops = 0, got_traps = 0, n;
        bit stopped = 0, ph = 0;
        n = (vl + 1) * sub;
        // Expected behaviour from the requirements.
        for (int e = 0; e < n; e++) begin
            int g = e / sub, s = e % sub;
            bit raw, f;
            if (stopped || g >= vl) continue;
            if (s == 0) ph = pmask[g];
            raw = (e == bad_e);
            if (mode == 1) begin
                f = ph & raw;
                if (f && g == 0) exp_traps++;
                else if (f) begin stopped = 1; exp_vl = g; exp_g = g; exp_s = s; exp_stops++; end
            end else if (mode == 2) begin
                f = ph ? raw : bit'(zm);
                if (f) begin stopped = 1; exp_vl = g; exp_g = g; exp_s = s; exp_stops++; end
            end
        end
        @(negedge clk);
        start = 1; vl_in = VL_W'(vl); subvl_m1 = SUB_W'(sub - 1);
        zero_mode = zm[0]; trap_en = mode[0]; cond_en = mode[1];
        elem_valid = 1; elem_trap = 1; elem_pass = 0; elem_pred = 1; // R2: ignored during start
        @(negedge clk);
        start = 0;
        check("R2 vl after start", vl_out, vl);
        check("R2 no strobe after start", {stop_pulse, trap_pass}, 0);
        for (int e = 0; e < n; e++) begin
            int g = e / sub, s = e % sub;
            elem_valid = 1;
            // R12: non-first elements carry an inverted predicate
            elem_pred = (s == 0) ? pmask[g] : ~pmask[g];
            elem_trap = (e == bad_e);
            elem_pass = (e != bad_e);
            @(negedge clk);
            got_stops += stop_pulse;
            got_traps += trap_pass;
        end
        elem_valid = 0; elem_trap = 0; elem_pass = 1;
        @(negedge clk);
        got_stops += stop_pulse;
        got_traps += trap_pass;
        // R4 R7 R8 R9 R5 R6 R11: truncated length
        check($sformatf("R4/R7/R9 vl m%0d z%0d s%0d v%0d b%0d p%0d", mode, zm, sub, vl, bad_e, pmask), vl_out, exp_vl);
        check("R11 stop count", got_stops, exp_stops);
        check("R3 trap hand-off count", got_traps, exp_traps);
        if (exp_stops != 0) begin
            check("R10 stop_group", stop_group, exp_g);
            check("R10 stop_sub", stop_sub, exp_s);
        end
        check("R1 mode_err", mode_err, (mode == 3) ? 1 : 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R2 reset vl_out", vl_out, 0);
        check("R2 reset strobes", {stop_pulse, trap_pass, mode_err}, 0);
        rst_n = 1;
        for (int mode = 1; mode <= 2; mode++)
            for (int zm = 0; zm <= 1; zm++)
                for (int sub = 1; sub <= 3; sub++)
                    for (int vl = 1; vl <= 4; vl++)
                        for (int pi = 0; pi < 4; pi++) begin
                            int pm = (pi == 0) ? 15 : (pi == 1) ? 0 : (pi == 2) ? 5 : 10;
                            for (int b = 0; b <= (vl + 1) * sub; b++)
                                run_op(mode, zm, sub, vl, b, pm);
                        end
        // R1: both modes requested; failing elements have no effect
        run_op(3, 1, 2, 3, 0, 0);
        run_op(3, 0, 1, 4, 2, 15);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule